// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers three transfer-completion events into one level-sensitive interrupt line. A programmed-I/O completion strobe, a DMA completion strobe and a buffer-threshold event each set their own sticky status bit. Each source also has a mask bit. A set mask keeps the source off the interrupt line, but its status bit still records events. Software clears a status bit by writing a one to it.

The buffer-threshold event comes from an internal counter of received-byte strobes. The event fires when the counter reaches either 32 or 64 bytes, as chosen by a select input. The counter then restarts from zero. A single-cycle register port writes the mask register, clears status bits, and reads back either register.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, all mask bits are 0 and `irq_o` is low.
- R2: Status bit positions: a `pio_done_i` pulse sets bit 2, a `dma_done_i` pulse sets bit 1, and a buffer-threshold event sets bit 0. Each bit is set at the clock edge that samples the event.
- R3: With `reg_sel_i`=1 (status), a write with a 1 in a bit position clears that status bit. A 0 in a bit position leaves that bit unchanged.
- R4: With `reg_sel_i`=0 (mask), a write loads the mask bits, using the same bit positions as the status bits. When a mask bit is 1, its status bit still sets on an event, but that source does not raise `irq_o`.
- R5: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It stays high until that condition ends.
- R6: When `thresh_small_i`=1, the buffer event fires on the 32nd received-byte strobe. When `thresh_small_i`=0, it fires on the 64th.
- R7: The received-byte count returns to zero when the buffer event fires, so the next event needs a full new threshold of strobes.
- R8: If an event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `reg_rdata_o` shows the mask bits when `reg_sel_i`=0 and the raw status bits when `reg_sel_i`=1, whatever the masking. The bits above bit 2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pio_done_i | input | 1 | One-cycle programmed-I/O completion strobe |
| dma_done_i | input | 1 | One-cycle DMA completion strobe |
| rx_byte_i | input | 1 | One-cycle strobe for each received byte |
| thresh_small_i | input | 1 | Threshold select: 1 = 32 bytes, 0 = 64 bytes |
| reg_wr_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 = mask, 1 = status |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| irq_o | output | 1 | Level interrupt output |

## Verification
The properties assume that every event input is a single-cycle strobe sampled on the rising edge. They also assume that a register write lasts exactly one cycle with stable select and data. Both are single-cycle conditions, so no property needs to look further back than one cycle. The stimulus drives every input just after a falling edge and holds it for exactly one clock. Outputs are sampled at the following falling edge. This keeps every event and write to one clean sampled cycle, including the cycle where a clear and an event hit the same bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_BUF = 0;
    localparam int SRC_DMA = 1;
    localparam int SRC_PIO = 2;

    typedef enum logic {
        REG_MASK = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/evt_byte_thresh.sv
module evt_byte_thresh #(
    parameter int SMALL_BYTES = 32,
    parameter int LARGE_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_i,
    input  logic sel_small_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(LARGE_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W:0] next_cnt;
    logic [CNT_W:0] limit;

    always_comb begin
        st_d     = st_q;
        hit_o    = 1'b0;
        limit    = sel_small_i ? (CNT_W+1)'(SMALL_BYTES) : (CNT_W+1)'(LARGE_BYTES);
        next_cnt = {1'b0, st_q.cnt} + 1'b1;
        if (byte_i) begin
            if (next_cnt >= limit) begin
                hit_o    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = next_cnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evt_stat_regs.sv
module evt_stat_regs
    import evt_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_en_i,
    input  reg_sel_e     sel_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] mask_o
);
    typedef struct packed {
        logic [N-1:0] stat;
        logic [N-1:0] mask;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = (wr_en_i && sel_i == REG_STAT) ? wdata_i : '0;
        for (int i = 0; i < N; i++) begin
            // A new event wins over a clear in the same cycle
            st_d.stat[i] = evt_i[i] | (st_q.stat[i] & ~clr[i]);
        end
        if (wr_en_i && sel_i == REG_MASK) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    logic [N-1:0] pend;

    for (genvar g = 0; g < N; g++) begin : g_pend
        assign pend[g] = stat_i[g] & ~mask_i[g];
    end

    assign irq_o = |pend;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SMALL_BYTES = 32,
    parameter int LARGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pio_done_i,
    input  logic              dma_done_i,
    input  logic              rx_byte_i,
    input  logic              thresh_small_i,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic               buf_hit;
    logic [NUM_SRC-1:0] evt_w;
    logic [NUM_SRC-1:0] stat_w;
    logic [NUM_SRC-1:0] mask_w;
    reg_sel_e           sel_w;

    assign sel_w = reg_sel_e'(reg_sel_i);

    always_comb begin
        evt_w          = '0;
        evt_w[SRC_PIO] = pio_done_i;
        evt_w[SRC_DMA] = dma_done_i;
        evt_w[SRC_BUF] = buf_hit;
    end

    evt_byte_thresh #(
        .SMALL_BYTES(SMALL_BYTES),
        .LARGE_BYTES(LARGE_BYTES)
    ) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (rx_byte_i),
        .sel_small_i(thresh_small_i),
        .hit_o      (buf_hit)
    );

    evt_stat_regs #(.N(NUM_SRC)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_w),
        .wr_en_i(reg_wr_i),
        .sel_i  (sel_w),
        .wdata_i(reg_wdata_i[NUM_SRC-1:0]),
        .stat_o (stat_w),
        .mask_o (mask_w)
    );

    evt_irq_merge #(.N(NUM_SRC)) u_merge (
        .stat_i(stat_w),
        .mask_i(mask_w),
        .irq_o (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        reg_rdata_o[NUM_SRC-1:0] = (sel_w == REG_STAT) ? stat_w : mask_w;
    end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pio,
    input logic       dma,
    input logic       wr,
    input logic       sel,
    input logic [2:0] wdata,
    input logic [2:0] stat,
    input logic [2:0] mask,
    input logic       irq
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat == 3'b000 && mask == 3'b000));

    // R2
    pio_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pio |=> stat[2]);

    // R2
    dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma |=> stat[1]);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel && wdata[2] && !pio) |=> !stat[2]);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[1] && !(wr && sel && wdata[1])) |=> stat[1]);

    // R8
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pio && wr && sel && wdata[2]) |=> stat[2]);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~mask) == 3'b000) |-> !irq);

    // R5
    pending_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~mask) != 3'b000) |-> irq);
endmodule

bind evt_irq_ctrl evt_irq_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pio  (pio_done_i),
    .dma  (dma_done_i),
    .wr   (reg_wr_i),
    .sel  (reg_sel_i),
    .wdata(reg_wdata_i[2:0]),
    .stat (stat_w),
    .mask (mask_w),
    .irq  (irq_o)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pio_done_i = 1'b0;
    logic              dma_done_i = 1'b0;
    logic              rx_byte_i = 1'b0;
    logic              thresh_small_i = 1'b1;
    logic              reg_wr_i = 1'b0;
    logic              reg_sel_i = 1'b0;
    logic [DATA_W-1:0] reg_wdata_i = '0;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_irq_ctrl #(.DATA_W(DATA_W)) u_evt_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pio_done_i    (pio_done_i),
        .dma_done_i    (dma_done_i),
        .rx_byte_i     (rx_byte_i),
        .thresh_small_i(thresh_small_i),
        .reg_wr_i      (reg_wr_i),
        .reg_sel_i     (reg_sel_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .irq_o         (irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel, output int val);
        reg_sel_i = sel;
        #1;
        val = int'(reg_rdata_o);
    endtask

    task automatic expect_reg(input logic sel, input int exp, input string req);
        int v;
        read_reg(sel, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic expect_irq(input bit exp, input string req);
        check(irq_o == exp, req, int'(irq_o), int'(exp));
    endtask

    task automatic write_reg(input logic sel, input int data);
        reg_wr_i    = 1'b1;
        reg_sel_i   = sel;
        reg_wdata_i = DATA_W'(data);
        @(negedge clk);
        reg_wr_i    = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic pulse_pio();
        pio_done_i = 1'b1;
        @(negedge clk);
        pio_done_i = 1'b0;
    endtask

    task automatic pulse_dma();
        dma_done_i = 1'b1;
        @(negedge clk);
        dma_done_i = 1'b0;
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            rx_byte_i = 1'b1;
            @(negedge clk);
            rx_byte_i = 1'b0;
            if (i % 3 == 2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        expect_reg(1'b1, 0, "R1 status");
        expect_reg(1'b0, 0, "R1 mask");
        expect_irq(1'b0, "R1 irq");
    endtask

    task automatic t_sources();
        pulse_pio();
        expect_reg(1'b1, 4, "R2 pio bit2");
        expect_irq(1'b1, "R5 irq on pio");
        write_reg(1'b1, 4);
        expect_reg(1'b1, 0, "R3 clear bit2");
        expect_irq(1'b0, "R5 irq drops");
        pulse_dma();
        expect_reg(1'b1, 2, "R2 dma bit1");
        write_reg(1'b1, 5);
        expect_reg(1'b1, 2, "R3 zero leaves bit1");
        expect_irq(1'b1, "R5 irq level held");
        write_reg(1'b1, 2);
        expect_reg(1'b1, 0, "R3 clear bit1");
    endtask

    task automatic t_mask();
        write_reg(1'b0, 7);
        expect_reg(1'b0, 7, "R9 mask readback");
        pulse_pio();
        pulse_dma();
        expect_reg(1'b1, 6, "R4 masked status records");
        expect_irq(1'b0, "R4 masked irq low");
        write_reg(1'b0, 3);
        expect_irq(1'b1, "R5 unmask bit2 raises irq");
        write_reg(1'b1, 4);
        expect_irq(1'b0, "R4 only masked dma pending");
        expect_reg(1'b1, 2, "R9 raw status under mask");
        write_reg(1'b0, 0);
        expect_irq(1'b1, "R5 unmask dma");
        write_reg(1'b1, 2);
        expect_irq(1'b0, "R5 cleared");
    endtask

    task automatic t_thresh_small();
        thresh_small_i = 1'b1;
        send_bytes(31);
        expect_reg(1'b1, 0, "R6 31 bytes no event");
        send_bytes(1);
        expect_reg(1'b1, 1, "R6 32nd byte sets bit0");
        expect_irq(1'b1, "R5 buffer irq");
        write_reg(1'b1, 1);
        send_bytes(31);
        expect_reg(1'b1, 0, "R7 count restarted");
        send_bytes(1);
        expect_reg(1'b1, 1, "R7 second threshold");
        write_reg(1'b1, 1);
    endtask

    task automatic t_thresh_large();
        thresh_small_i = 1'b0;
        send_bytes(63);
        expect_reg(1'b1, 0, "R6 63 bytes no event");
        send_bytes(1);
        expect_reg(1'b1, 1, "R6 64th byte sets bit0");
        write_reg(1'b1, 1);
        thresh_small_i = 1'b1;
    endtask

    task automatic t_collide();
        pulse_pio();
        pio_done_i  = 1'b1;
        reg_wr_i    = 1'b1;
        reg_sel_i   = 1'b1;
        reg_wdata_i = DATA_W'(4);
        @(negedge clk);
        pio_done_i  = 1'b0;
        reg_wr_i    = 1'b0;
        reg_wdata_i = '0;
        expect_reg(1'b1, 4, "R8 event beats clear");
        write_reg(1'b1, 4);
        expect_reg(1'b1, 0, "R8 later clear works");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_mask();
        t_thresh_small();
        t_thresh_large();
        t_collide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule